// File: doc/BRIEF.md
# Packed Conversion Result FIFO

This block sits behind a free-running 12-bit converter. The converter works in repeat mode. After one start command, a result strobe arrives for every conversion, and no per-sample rearm is needed. Storing continues until a stop command.

Results land in twelve numbered result slots in arrival order, wrapping from the last slot back to slot 0. A reader, normally a DMA engine, pulls them out as 32-bit words. Each word carries two results: the older one in the lower half-word and the newer one in the upper half-word.

The reader is paced by a request pulse. The pulse fires when a chosen slot number receives a result. The reader never learns how many results are waiting. It learns about trouble only from two sticky flags, one for overflow and one for underflow. A parameter picks what happens at full. The default drops the incoming result. The alternative writes the incoming result over the oldest unread slot, so later reads can come back out of chronological order.

Top module: `packed_result_fifo`

## Requirements
- R1: After reset, ovf_o, udf_o and dma_req_o are 0, rd_data_o is 0, and the FIFO holds no results.
- R2: A result is stored only when the block is running. Running begins on the clock edge after start_i and ends when stop_i is seen. A result that arrives in the same cycle as start_i is not stored. A result that arrives in the same cycle as stop_i is not stored. When start_i and stop_i are asserted together, stop_i wins.
- R3: A read strobe on rd_i returns a word on rd_data_o in the next cycle. Bits [15:0] hold the older result of the pair and bits [31:16] hold the newer result, each zero-extended from 12 bits. rd_data_o changes only after an accepted read.
- R4: Results are written to slots 0 to 11 in turn and wrap from slot 11 to slot 0. Word k is formed from slots 2k and 2k+1. Words are returned in order 0 to 5 and then wrap to word 0.
- R5: dma_req_o is high for exactly one cycle, the cycle after a result is stored into the slot whose number equals req_slot_i. With a value of 11 it fires once every twelve stored results. A value of 12 to 15 never fires.
- R6: In the default drop policy, a result that arrives while all 12 slots hold unread results is discarded. ovf_o goes high in the next cycle, and no request pulse is produced for the discarded result.
- R7: A read strobe while fewer than two unread results are held leaves rd_data_o and the read position unchanged, and sets udf_o in the next cycle.
- R8: ovf_o and udf_o stay high until their clear input (ovf_clr_i or udf_clr_i) is pulsed. If a new event and its clear occur in the same cycle, the event wins.
- R9: A read and a new result in the same cycle at full: the read frees space first, so the result is stored and ovf_o is not set.
- R10: Results stored before a stop remain readable after it.
- R11: In the overwrite policy, a result arriving at full is written into the next slot, replacing the oldest unread result, and ovf_o is set. The next read of that word returns the new result in the lower half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start repeated conversions |
| stop_i | input | 1 | Stop storing results |
| res_valid_i | input | 1 | Conversion result strobe |
| res_data_i | input | 12 | Conversion result |
| req_slot_i | input | 4 | Slot number whose loading raises the request |
| rd_i | input | 1 | Read one 32-bit word |
| ovf_clr_i | input | 1 | Write-one-to-clear for overflow flag |
| udf_clr_i | input | 1 | Write-one-to-clear for underflow flag |
| rd_data_o | output | 32 | Packed pair of results |
| dma_req_o | output | 1 | One-cycle request pulse |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |

## Verification
A word read and a result arrival can coincide when all twelve slots are full. The bench fills the FIFO and then asserts rd_i and res_valid_i on the same edge. It expects the oldest word on rd_data_o, no overflow, and the new result to come back later paired with the next one after the slot wrap. A flag event can also coincide with its own clear. The bench provokes an overflow and an empty read each while pulsing the matching clear, and expects the flag to be left set.

// File: rtl/packed_result_fifo_pkg.sv
package packed_result_fifo_pkg;
  // Policy applied when a result arrives and every slot is unread
  typedef enum logic {
    OVF_DROP      = 1'b0,
    OVF_OVERWRITE = 1'b1
  } ovf_policy_e;

  // Results carried in each output word
  localparam int unsigned LANES = 2;
endpackage

// File: rtl/result_bank.sv
module result_bank #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned W     = 12,
  parameter int unsigned AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // read-first registered port
  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/fill_tracker.sv
module fill_tracker #(
  parameter int unsigned SLOTS = 12,
  parameter bit          DROP  = 1'b1,
  localparam int unsigned WORDS   = SLOTS / 2,
  localparam int unsigned SLOT_W  = $clog2(SLOTS),
  localparam int unsigned WORD_AW = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_req_i,
  input  logic               rd_req_i,
  input  logic               ovf_clr_i,
  input  logic               udf_clr_i,
  output logic               wr_en_o,
  output logic [SLOT_W-1:0]  wr_slot_o,
  output logic               rd_en_o,
  output logic [WORD_AW-1:0] rd_word_o,
  output logic               ovf_o,
  output logic               udf_o
);
  localparam int unsigned CW = $clog2(SLOTS + 1);

  logic [CW-1:0] unread_q;
  logic have_word, room, ovf_evt, udf_evt;

  assign have_word = unread_q >= CW'(2);
  assign rd_en_o   = rd_req_i && have_word;
  assign room      = (unread_q < CW'(SLOTS)) || rd_en_o;
  assign ovf_evt   = wr_req_i && !room;
  assign udf_evt   = rd_req_i && !have_word;

  generate
    if (DROP) begin : g_drop
      assign wr_en_o = wr_req_i && room;
    end else begin : g_overwrite
      assign wr_en_o = wr_req_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      unread_q  <= '0;
      wr_slot_o <= '0;
      rd_word_o <= '0;
      ovf_o     <= 1'b0;
      udf_o     <= 1'b0;
    end else begin
      if (wr_en_o)
        wr_slot_o <= (wr_slot_o == SLOT_W'(SLOTS - 1)) ? '0 : wr_slot_o + 1'b1;
      if (rd_en_o)
        rd_word_o <= (rd_word_o == WORD_AW'(WORDS - 1)) ? '0 : rd_word_o + 1'b1;
      unread_q <= unread_q + ((wr_en_o && room) ? CW'(1) : CW'(0))
                           - (rd_en_o ? CW'(2) : CW'(0));
      if (ovf_evt)        ovf_o <= 1'b1;
      else if (ovf_clr_i) ovf_o <= 1'b0;
      if (udf_evt)        udf_o <= 1'b1;
      else if (udf_clr_i) udf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/req_gen.sv
module req_gen #(
  parameter int unsigned SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [SLOT_W-1:0] sel_i,
  output logic              req_o
);
  always_ff @(posedge clk) begin
    if (rst) req_o <= 1'b0;
    else     req_o <= wr_en_i && (wr_slot_i == sel_i);
  end
endmodule

// File: rtl/packed_result_fifo.sv
module packed_result_fifo #(
  parameter int unsigned RES_W  = 12,
  parameter int unsigned SLOTS  = 12,
  parameter int unsigned HALF_W = 16,
  parameter packed_result_fifo_pkg::ovf_policy_e OVF_POLICY = packed_result_fifo_pkg::OVF_DROP,
  localparam int unsigned WORDS   = SLOTS / 2,
  localparam int unsigned SLOT_W  = $clog2(SLOTS),
  localparam int unsigned WORD_AW = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                res_valid_i,
  input  logic [RES_W-1:0]    res_data_i,
  input  logic [SLOT_W-1:0]   req_slot_i,
  input  logic                rd_i,
  input  logic                ovf_clr_i,
  input  logic                udf_clr_i,
  output logic [2*HALF_W-1:0] rd_data_o,
  output logic                dma_req_o,
  output logic                ovf_o,
  output logic                udf_o
);
  localparam bit DROP = (OVF_POLICY == packed_result_fifo_pkg::OVF_DROP);

  logic running_q, wr_req, wr_en, rd_en;
  logic [SLOT_W-1:0]  wr_slot;
  logic [WORD_AW-1:0] rd_word;
  logic [RES_W-1:0]   lane_q [packed_result_fifo_pkg::LANES];

  always_ff @(posedge clk) begin
    if (rst)          running_q <= 1'b0;
    else if (stop_i)  running_q <= 1'b0;
    else if (start_i) running_q <= 1'b1;
  end

  assign wr_req = res_valid_i && running_q && !stop_i;

  fill_tracker #(.SLOTS(SLOTS), .DROP(DROP)) u_track (
    .clk(clk), .rst(rst), .wr_req_i(wr_req), .rd_req_i(rd_i),
    .ovf_clr_i(ovf_clr_i), .udf_clr_i(udf_clr_i),
    .wr_en_o(wr_en), .wr_slot_o(wr_slot), .rd_en_o(rd_en),
    .rd_word_o(rd_word), .ovf_o(ovf_o), .udf_o(udf_o)
  );

  req_gen #(.SLOT_W(SLOT_W)) u_req (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_slot_i(wr_slot),
    .sel_i(req_slot_i), .req_o(dma_req_o)
  );

  // even slots feed lane 0 (older), odd slots lane 1 (newer)
  generate
    for (genvar g = 0; g < packed_result_fifo_pkg::LANES; g++) begin : g_lane
      result_bank #(.DEPTH(WORDS), .W(RES_W), .AW(WORD_AW)) u_bank (
        .clk(clk), .rst(rst),
        .we_i(wr_en && (wr_slot[0] == 1'(g))),
        .waddr_i(wr_slot[SLOT_W-1:1]), .wdata_i(res_data_i),
        .re_i(rd_en), .raddr_i(rd_word), .rdata_o(lane_q[g])
      );
    end
  endgenerate

  assign rd_data_o = {HALF_W'(lane_q[1]), HALF_W'(lane_q[0])};
endmodule

// File: rtl/packed_result_fifo_chk.sv
module packed_result_fifo_chk #(
  parameter int unsigned DW        = 32,
  parameter bit          DROP_MODE = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_i,
  input logic          stop_i,
  input logic          ovf_clr_i,
  input logic          udf_clr_i,
  input logic [DW-1:0] rd_data_o,
  input logic          dma_req_o,
  input logic          ovf_o,
  input logic          udf_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!ovf_o && !udf_o && !dma_req_o && rd_data_o == '0));
  // R5
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req_o |=> !dma_req_o);
  // R2
  stop_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !dma_req_o);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  // R8
  udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (udf_o && !udf_clr_i) |=> udf_o);
  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rd_data_o));
  // R6
  drop_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (DROP_MODE && $rose(ovf_o)) |-> !dma_req_o);
endmodule

bind packed_result_fifo packed_result_fifo_chk #(
  .DW(2 * HALF_W),
  .DROP_MODE(OVF_POLICY == packed_result_fifo_pkg::OVF_DROP)
) u_chk (
  .clk(clk), .rst(rst), .rd_i(rd_i), .stop_i(stop_i),
  .ovf_clr_i(ovf_clr_i), .udf_clr_i(udf_clr_i), .rd_data_o(rd_data_o),
  .dma_req_o(dma_req_o), .ovf_o(ovf_o), .udf_o(udf_o)
);

// File: tb/sim_packed_result_fifo.sv
module sim_packed_result_fifo;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, stop_i = 0, res_valid_i = 0, rd_i = 0, ovf_clr_i = 0, udf_clr_i = 0;
  logic [11:0] res_data_i = '0;
  logic [3:0]  req_slot_i = '0;
  logic [31:0] rd0, rd1;
  logic dma0, dma1, ovf0, ovf1, udf0, udf1;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  packed_result_fifo u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .res_valid_i(res_valid_i),
    .res_data_i(res_data_i), .req_slot_i(req_slot_i), .rd_i(rd_i), .ovf_clr_i(ovf_clr_i),
    .udf_clr_i(udf_clr_i), .rd_data_o(rd0), .dma_req_o(dma0), .ovf_o(ovf0), .udf_o(udf0));

  packed_result_fifo #(.OVF_POLICY(packed_result_fifo_pkg::OVF_OVERWRITE)) u1 (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .res_valid_i(res_valid_i),
    .res_data_i(res_data_i), .req_slot_i(req_slot_i), .rd_i(rd_i), .ovf_clr_i(ovf_clr_i),
    .udf_clr_i(udf_clr_i), .rd_data_o(rd1), .dma_req_o(dma1), .ovf_o(ovf1), .udf_o(udf1));

  function automatic logic [11:0] val(int i);
    return 12'((i * 397 + 91) % 4096);
  endfunction

  function automatic logic [31:0] wd(logic [11:0] older, logic [11:0] newer);
    return {4'h0, newer, 4'h0, older};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; start_i = 0; stop_i = 0; res_valid_i = 0; rd_i = 0;
    ovf_clr_i = 0; udf_clr_i = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic pulse_start();
    start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic push(logic [11:0] v);
    res_valid_i = 1; res_data_i = v; @(negedge clk); res_valid_i = 0;
  endtask

  task automatic rd_word();
    rd_i = 1; @(negedge clk); rd_i = 0;
  endtask

  task automatic clr_udf();
    udf_clr_i = 1; @(negedge clk); udf_clr_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] hold;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(ovf0 == 0 && udf0 == 0 && dma0 == 0, "R1 flags", {ovf0, udf0, dma0}, 0);
    chk(rd0 == 0, "R1 data", rd0, 0);
    rd_word();
    chk(udf0 == 1, "R1/R7 empty after reset", udf0, 1);
    chk(rd0 == 0, "R7 data unchanged", rd0, 0);
    clr_udf();
    chk(udf0 == 0, "R8 udf clear", udf0, 0);

    // R2 no storing when idle
    push(val(0)); push(val(1)); push(val(2));
    rd_word();
    chk(udf0 == 1, "R2 idle results dropped", udf0, 1);

    // R5 sweep of the request slot, then R6/R3/R4/R11
    for (int s = 0; s <= 12; s++) begin
      do_reset();
      req_slot_i = 4'(s);
      pulse_start();
      for (int j = 0; j < 12; j++) begin
        push(val(j));
        chk(dma0 == (j == s), "R5 request slot", dma0, 32'(j == s));
      end
    end
    push(12'hABC);
    chk(ovf0 == 1 && dma0 == 0, "R6 drop at full", {ovf0, dma0}, 2);
    chk(ovf1 == 1, "R11 overwrite flag", ovf1, 1);
    rd_word();
    chk(rd0 == wd(val(0), val(1)), "R3 packing word0", rd0, wd(val(0), val(1)));
    chk(rd1 == wd(12'hABC, val(1)), "R11 overwritten slot", rd1, wd(12'hABC, val(1)));
    for (int k = 1; k < 6; k++) begin
      rd_word();
      chk(rd0 == wd(val(2*k), val(2*k+1)), "R4 order", rd0, wd(val(2*k), val(2*k+1)));
    end
    hold = rd0;
    rd_word();
    chk(udf0 == 1 && rd0 == hold, "R7 empty read", rd0, hold);
    repeat (4) @(negedge clk);
    chk(ovf0 == 1, "R8 ovf sticky", ovf0, 1);
    ovf_clr_i = 1; @(negedge clk); ovf_clr_i = 0;
    chk(ovf0 == 0, "R8 ovf clear", ovf0, 0);

    // R4 wrap with partial reads
    do_reset(); req_slot_i = 4'd15; pulse_start();
    for (int j = 0; j < 8; j++) push(val(100 + j));
    for (int k = 0; k < 3; k++) begin
      rd_word();
      chk(rd0 == wd(val(100 + 2*k), val(101 + 2*k)), "R4 first pass", rd0,
          wd(val(100 + 2*k), val(101 + 2*k)));
    end
    for (int j = 8; j < 16; j++) push(val(100 + j));
    for (int k = 3; k < 8; k++) begin
      rd_word();
      chk(rd0 == wd(val(100 + 2*k), val(101 + 2*k)), "R4 wrap", rd0,
          wd(val(100 + 2*k), val(101 + 2*k)));
    end
    chk(ovf0 == 0, "R4 no overflow", ovf0, 0);

    // R9 read and write together at full
    do_reset(); pulse_start();
    for (int j = 0; j < 12; j++) push(val(200 + j));
    rd_i = 1; res_valid_i = 1; res_data_i = 12'h5A5;
    @(negedge clk);
    rd_i = 0; res_valid_i = 0;
    chk(ovf0 == 0, "R9 no overflow", ovf0, 0);
    chk(rd0 == wd(val(200), val(201)), "R9 oldest word", rd0, wd(val(200), val(201)));
    for (int k = 1; k < 6; k++) rd_word();
    chk(rd0 == wd(val(210), val(211)), "R9 last word", rd0, wd(val(210), val(211)));
    rd_word();
    chk(udf0 == 1, "R7 half word only", udf0, 1);
    clr_udf();
    push(12'h123);
    rd_word();
    chk(rd0 == wd(12'h5A5, 12'h123), "R9/R4 wrapped pair", rd0, wd(12'h5A5, 12'h123));

    // R10 and R2 stop behaviour
    do_reset(); pulse_start();
    for (int j = 0; j < 4; j++) push(val(300 + j));
    stop_i = 1; res_valid_i = 1; res_data_i = val(304);
    @(negedge clk);
    stop_i = 0; res_valid_i = 0;
    push(val(305));
    rd_word();
    chk(rd0 == wd(val(300), val(301)), "R10 after stop", rd0, wd(val(300), val(301)));
    rd_word();
    chk(rd0 == wd(val(302), val(303)), "R10 after stop 2", rd0, wd(val(302), val(303)));
    rd_word();
    chk(udf0 == 1, "R2 stop blocks results", udf0, 1);
    clr_udf();
    start_i = 1; stop_i = 1; @(negedge clk); start_i = 0; stop_i = 0;
    push(val(306)); push(val(307));
    rd_word();
    chk(udf0 == 1, "R2 stop wins over start", udf0, 1);
    clr_udf();
    start_i = 1; res_valid_i = 1; res_data_i = 12'h0F0;
    @(negedge clk);
    start_i = 0; res_data_i = 12'h111;
    @(negedge clk);
    res_data_i = 12'h222;
    @(negedge clk);
    res_valid_i = 0;
    rd_word();
    chk(rd0 == wd(12'h111, 12'h222), "R2 start-cycle result skipped", rd0,
        wd(12'h111, 12'h222));

    // R8 event beats clear
    do_reset(); pulse_start();
    for (int j = 0; j < 12; j++) push(val(j));
    ovf_clr_i = 1; res_valid_i = 1; res_data_i = 12'h777;
    @(negedge clk);
    ovf_clr_i = 0; res_valid_i = 0;
    chk(ovf0 == 1, "R8 ovf set wins", ovf0, 1);
    do_reset();
    rd_i = 1; udf_clr_i = 1; @(negedge clk); rd_i = 0; udf_clr_i = 0;
    chk(udf0 == 1, "R8 udf set wins", udf0, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule